// File: doc/BRIEF.md
# Clock Synthesizer Feedback and Output Divider Control

This block is the digital side of a phase-locked frequency synthesizer. It holds a control register with three fields: a prescale select (W), an output pass select (X) and a 6-bit loop modulus (Y). The VCO clock is divided in the feedback path by a prescaler of 1 or 4 chained with a modulo-(Y+1) counter. The result is a one-cycle feedback pulse for an external phase detector. In the output path, the VCO clock is either halved or passed through unchanged to form the system clock.

A lock state machine models loop settling. A write that alters W or Y puts the loop into its relock state, and the lock flag stays low until a set number of reference-clock rising edges has been seen. A write that alters only X changes the system clock at once and leaves lock untouched. Each write is screened against a VCO ceiling, expressed as a largest allowed feedback multiplier. A write that would exceed it sets a sticky error flag, but the write is still applied. Software is expected to write lower-VCO settings before higher ones when a change takes several writes.

The lock machine has two states. ST_RELOCK counts synchronized reference rising edges. ST_LOCKED reports lock. The transitions are: reset enters ST_RELOCK; ST_RELOCK goes to ST_LOCKED once the edge count reaches the relock length; ST_LOCKED goes to ST_RELOCK on a feedback-changing write; and a feedback-changing write seen in ST_RELOCK clears the count and stays in ST_RELOCK.

Top module: `clk_synth_ctrl`

## Requirements
- R1: After reset W=0, X=0, Y=63, lock is low and the over-limit flag is low. A write with wr_en high loads all three fields, which are visible on w_q, x_q and y_q after the next vco_clk rising edge.
- R2: The feedback multiplier is M=(Y+1)*(W ? 4 : 1). fb_pulse is high for one vco_clk cycle once every M cycles, and stays high continuously when M=1.
- R3: When M>1 and no write occurs, fb_pulse is never high in two consecutive vco_clk cycles.
- R4: With X=1, sys_clk equals vco_clk. With X=0, sys_clk toggles at half the vco_clk rate.
- R5: A write whose W or Y differs from the held value drops lock on the next vco_clk edge. Lock returns after RELOCK_EDGES rising edges of ref_clk.
- R6: A write that changes only X, or changes nothing, leaves lock as it was.
- R7: A write that changes W or Y while relocking restarts the relock edge count from zero.
- R8: A write whose multiplier M exceeds MULT_MAX (default 200) sets over_limit. M equal to MULT_MAX does not set it. over_limit stays set until reset, and the write is still applied.
- R9: After reset is released, lock rises once RELOCK_EDGES reference rising edges have been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO clock, clocks all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock, sampled and edge-detected |
| wr_en | input | 1 | Register write strobe |
| wr_w | input | 1 | Prescale select to write |
| wr_x | input | 1 | Output pass select to write |
| wr_y | input | 6 | Loop modulus to write |
| w_q | output | 1 | Held prescale select |
| x_q | output | 1 | Held output pass select |
| y_q | output | 6 | Held loop modulus |
| fb_pulse | output | 1 | Feedback pulse to the phase detector |
| sys_clk | output | 1 | System clock |
| lock | output | 1 | Loop lock flag |
| over_limit | output | 1 | Sticky VCO over-limit error |

## Verification
The settings are applied in an order chosen to separate the effects. There are X-only writes, Y-only and W-only changes, the extreme moduli (M=1 and M=256 territory), and the multiplier exactly at and just above the ceiling. The measured fb_pulse spacing tells the two prescale values apart and shows an off-by-one in the modulus. Counting sys_clk edges tells pass mode from halving mode. Sampling lock just before and after the expected relock time separates a change that needs relock from an X-only change, and shows whether a second change made mid-relock restarts the count.

// File: rtl/clk_synth_pkg.sv
package clk_synth_pkg;

    typedef enum logic [0:0] {
        ST_RELOCK = 1'b0,
        ST_LOCKED = 1'b1
    } lock_st_t;

endpackage

// File: rtl/csd_ctrl_reg.sv
module csd_ctrl_reg #(
    parameter int Y_W      = 6,
    parameter int PRE_LO   = 1,
    parameter int PRE_HI   = 4,
    parameter int MULT_MAX = 200
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_w,
    input  logic           wr_x,
    input  logic [Y_W-1:0] wr_y,
    output logic           w_q,
    output logic           x_q,
    output logic [Y_W-1:0] y_q,
    output logic           fb_change,
    output logic           over_limit
);
    localparam int MULT_W = Y_W + $clog2(PRE_HI) + 2;

    logic [MULT_W-1:0] new_mult;
    logic              too_fast;

    // multiplier the pending write would produce
    always_comb begin
        new_mult = (MULT_W'(wr_y) + MULT_W'(1)) * MULT_W'(wr_w ? PRE_HI : PRE_LO);
        too_fast = new_mult > MULT_W'(MULT_MAX);
        fb_change = wr_en && ((wr_w != w_q) || (wr_y != y_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q        <= 1'b0;
            x_q        <= 1'b0;
            y_q        <= '1;
            over_limit <= 1'b0;
        end else if (wr_en) begin
            w_q <= wr_w;
            x_q <= wr_x;
            y_q <= wr_y;
            if (too_fast) begin
                over_limit <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/csd_fb_div.sv
module csd_fb_div #(
    parameter int Y_W    = 6,
    parameter int PRE_LO = 1,
    parameter int PRE_HI = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           w,
    input  logic [Y_W-1:0] y,
    output logic           fb_pulse
);
    localparam int PW = $clog2(PRE_HI + 1);

    logic [PW-1:0]  pre_cnt;
    logic [PW-1:0]  pre_lim;
    logic [Y_W-1:0] mod_cnt;

    always_comb begin
        pre_lim = w ? PW'(PRE_HI - 1) : PW'(PRE_LO - 1);
    end

    // prescaler feeds the modulo counter; carry out of both is the pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            mod_cnt  <= '0;
            fb_pulse <= 1'b0;
        end else if (restart) begin
            pre_cnt  <= '0;
            mod_cnt  <= '0;
            fb_pulse <= 1'b0;
        end else begin
            fb_pulse <= 1'b0;
            if (pre_cnt == pre_lim) begin
                pre_cnt <= '0;
                if (mod_cnt == y) begin
                    mod_cnt  <= '0;
                    fb_pulse <= 1'b1;
                end else begin
                    mod_cnt <= mod_cnt + 1'b1;
                end
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/csd_out_stage.sv
module csd_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic pass_req,
    output logic sys_clk
);
    logic half_q;
    logic sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
        end
    end

    // select changes only while both sources are low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (!half_q) begin
            sel_q <= pass_req;
        end
    end

    always_comb begin
        sys_clk = sel_q ? clk : half_q;
    end

endmodule

// File: rtl/csd_lock_fsm.sv
module csd_lock_fsm
    import clk_synth_pkg::*;
#(
    parameter int RELOCK_EDGES = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic restart,
    output logic lock
);
    localparam int CW = $clog2(RELOCK_EDGES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ref_prev;
    logic                   ref_edge;
    lock_st_t               st_q, st_d;
    logic [CW-1:0]          cnt_q, cnt_d;

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[gi] <= 1'b0;
                end else begin
                    sync_q[gi] <= (gi == 0) ? ref_clk : sync_q[(gi == 0) ? 0 : gi - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_prev <= 1'b0;
        end else begin
            ref_prev <= sync_q[SYNC_STAGES-1];
        end
    end

    always_comb begin
        ref_edge = sync_q[SYNC_STAGES-1] & ~ref_prev;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RELOCK;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_LOCKED: begin
                if (restart) begin
                    st_d  = ST_RELOCK;
                    cnt_d = '0;
                end
            end
            ST_RELOCK: begin
                if (restart) begin
                    cnt_d = '0;
                end else if (ref_edge) begin
                    if (cnt_q == CW'(RELOCK_EDGES - 1)) begin
                        st_d  = ST_LOCKED;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d  = ST_RELOCK;
                cnt_d = '0;
            end
        endcase
        lock = (st_q == ST_LOCKED);
    end

endmodule

// File: rtl/clk_synth_ctrl.sv
module clk_synth_ctrl #(
    parameter int Y_W          = 6,
    parameter int PRE_LO       = 1,
    parameter int PRE_HI       = 4,
    parameter int MULT_MAX     = 200,
    parameter int RELOCK_EDGES = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic           vco_clk,
    input  logic           rst_n,
    input  logic           ref_clk,
    input  logic           wr_en,
    input  logic           wr_w,
    input  logic           wr_x,
    input  logic [Y_W-1:0] wr_y,
    output logic           w_q,
    output logic           x_q,
    output logic [Y_W-1:0] y_q,
    output logic           fb_pulse,
    output logic           sys_clk,
    output logic           lock,
    output logic           over_limit
);
    logic fb_change;

    csd_ctrl_reg #(
        .Y_W(Y_W), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .MULT_MAX(MULT_MAX)
    ) u_reg (
        .clk(vco_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_w(wr_w),
        .wr_x(wr_x), .wr_y(wr_y), .w_q(w_q), .x_q(x_q), .y_q(y_q),
        .fb_change(fb_change), .over_limit(over_limit)
    );

    csd_fb_div #(
        .Y_W(Y_W), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)
    ) u_fb (
        .clk(vco_clk), .rst_n(rst_n), .restart(fb_change),
        .w(w_q), .y(y_q), .fb_pulse(fb_pulse)
    );

    csd_out_stage u_out (
        .clk(vco_clk), .rst_n(rst_n), .pass_req(x_q), .sys_clk(sys_clk)
    );

    csd_lock_fsm #(
        .RELOCK_EDGES(RELOCK_EDGES), .SYNC_STAGES(SYNC_STAGES)
    ) u_lock (
        .clk(vco_clk), .rst_n(rst_n), .ref_clk(ref_clk),
        .restart(fb_change), .lock(lock)
    );

endmodule

// File: rtl/clk_synth_ctrl_chk.sv
module clk_synth_ctrl_chk #(
    parameter int Y_W    = 6,
    parameter int PRE_LO = 1,
    parameter int PRE_HI = 4
) (
    input logic           vco_clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic           wr_w,
    input logic           wr_x,
    input logic [Y_W-1:0] wr_y,
    input logic           w_q,
    input logic           x_q,
    input logic [Y_W-1:0] y_q,
    input logic           fb_pulse,
    input logic           lock,
    input logic           over_limit
);
    logic multi_cycle;
    always_comb begin
        multi_cycle = (y_q != '0) || ((w_q ? PRE_HI : PRE_LO) != 1);
    end

    AST_WRITE_LOADS: assert property (@(posedge vco_clk) disable iff (!rst_n)
        wr_en |=> (w_q == $past(wr_w) && x_q == $past(wr_x) && y_q == $past(wr_y))); // R1

    AST_FB_NO_BACK_TO_BACK: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (fb_pulse && !wr_en && multi_cycle) |=> !fb_pulse); // R3

    AST_FB_CHANGE_DROPS_LOCK: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (wr_en && (wr_w != w_q || wr_y != y_q)) |=> !lock); // R5

    AST_X_ONLY_KEEPS_LOCK: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (lock && wr_en && wr_w == w_q && wr_y == y_q) |=> lock); // R6

    AST_ERR_STICKY: assert property (@(posedge vco_clk) disable iff (!rst_n)
        over_limit |=> over_limit); // R8

endmodule

bind clk_synth_ctrl clk_synth_ctrl_chk #(
    .Y_W(Y_W), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)
) u_chk (
    .vco_clk(vco_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_w(wr_w),
    .wr_x(wr_x), .wr_y(wr_y), .w_q(w_q), .x_q(x_q), .y_q(y_q),
    .fb_pulse(fb_pulse), .lock(lock), .over_limit(over_limit)
);

// File: tb/clk_synth_ctrl_bench.sv
module clk_synth_ctrl_bench;
    localparam int RELOCK = 8;
    localparam int REF_CYC = 16;
    localparam int NVEC = 8;

    logic       vco_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_w = 1'b0;
    logic       wr_x = 1'b0;
    logic [5:0] wr_y = '0;
    logic       w_q, x_q, fb_pulse, sys_clk, lock, over_limit;
    logic [5:0] y_q;

    int n_chk = 0;
    int n_bad = 0;
    int sys_edges = 0;

    // {w, x, y[5:0], mult[8:0], relock, err}
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 6'd63, 9'd64,  1'b0, 1'b0},
        {1'b0, 1'b1, 6'd15, 9'd16,  1'b1, 1'b0},
        {1'b1, 1'b1, 6'd15, 9'd64,  1'b1, 1'b0},
        {1'b1, 1'b0, 6'd15, 9'd64,  1'b0, 1'b0},
        {1'b0, 1'b0, 6'd0,  9'd1,   1'b1, 1'b0},
        {1'b1, 1'b0, 6'd49, 9'd200, 1'b1, 1'b0},
        {1'b1, 1'b1, 6'd50, 9'd204, 1'b1, 1'b1},
        {1'b0, 1'b1, 6'd3,  9'd4,   1'b1, 1'b1}
    };

    clk_synth_ctrl u_clk_synth_ctrl (
        .vco_clk(vco_clk), .rst_n(rst_n), .ref_clk(ref_clk), .wr_en(wr_en),
        .wr_w(wr_w), .wr_x(wr_x), .wr_y(wr_y), .w_q(w_q), .x_q(x_q),
        .y_q(y_q), .fb_pulse(fb_pulse), .sys_clk(sys_clk), .lock(lock),
        .over_limit(over_limit)
    );

    always #5 vco_clk = ~vco_clk;
    always #80 ref_clk = ~ref_clk;
    always @(posedge sys_clk) sys_edges++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge vco_clk);
    endtask

    task automatic write(input logic w, input logic x, input logic [5:0] y);
        @(negedge vco_clk);
        wr_en = 1'b1; wr_w = w; wr_x = x; wr_y = y;
        @(negedge vco_clk);
        wr_en = 1'b0;
    endtask

    task automatic fb_interval(output int gap);
        int guard = 0;
        gap = 0;
        while (!fb_pulse && guard < 3000) begin cyc(1); guard++; end
        cyc(1); gap = 1;
        while (!fb_pulse && gap < 3000) begin cyc(1); gap++; end
    endtask

    task automatic sys_rate(output int cnt);
        int start;
        cyc(4);
        start = sys_edges;
        cyc(64);
        cnt = sys_edges - start;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int gap, cnt, exp_sys;
        cyc(3);
        // R1: reset values
        chk(w_q == 1'b0 && x_q == 1'b0, "R1 reset W/X", {w_q, x_q}, 0);
        chk(y_q == 6'd63, "R1 reset Y", y_q, 63);
        chk(lock == 1'b0 && over_limit == 1'b0, "R1 reset flags", {lock, over_limit}, 0);
        rst_n = 1'b1;
        // R9: lock after reset
        cyc((RELOCK - 2) * REF_CYC);
        chk(lock == 1'b0, "R9 early lock", lock, 0);
        cyc(4 * REF_CYC);
        chk(lock == 1'b1, "R9 lock after reset", lock, 1);
        // R2: reset multiplier 64
        fb_interval(gap);
        chk(gap == 64, "R2 reset spacing", gap, 64);
        // R4: halving after reset
        sys_rate(cnt);
        chk(cnt >= 31 && cnt <= 33, "R4 reset halving", cnt, 32);

        for (int i = 0; i < NVEC; i++) begin
            write(VEC[i][18], VEC[i][17], VEC[i][16:11]);
            chk(w_q == VEC[i][18] && x_q == VEC[i][17] && y_q == VEC[i][16:11],
                "R1 write load", {w_q, x_q, y_q}, VEC[i][18:11]);
            if (VEC[i][1]) begin
                chk(lock == 1'b0, "R5 lock drop", lock, 0);
                cyc((RELOCK - 2) * REF_CYC);
                chk(lock == 1'b0, "R5 still relocking", lock, 0);
                cyc(4 * REF_CYC);
                chk(lock == 1'b1, "R5 relocked", lock, 1);
            end else begin
                chk(lock == 1'b1, "R6 lock kept", lock, 1);
                cyc(2 * REF_CYC);
                chk(lock == 1'b1, "R6 lock still kept", lock, 1);
            end
            chk(over_limit == VEC[i][0], "R8 over-limit flag", over_limit, VEC[i][0]);
            fb_interval(gap);
            chk(gap == int'(VEC[i][10:2]), "R2 feedback spacing", gap, int'(VEC[i][10:2]));
            sys_rate(cnt);
            exp_sys = VEC[i][17] ? 64 : 32;
            chk(cnt >= exp_sys - 1 && cnt <= exp_sys + 1, "R4 system clock rate", cnt, exp_sys);
        end

        // R7: second feedback change during relock restarts the count
        write(1'b0, 1'b1, 6'd20);
        cyc(5 * REF_CYC);
        write(1'b0, 1'b1, 6'd21);
        cyc(5 * REF_CYC);
        chk(lock == 1'b0, "R7 count restarted", lock, 0);
        cyc(5 * REF_CYC);
        chk(lock == 1'b1, "R7 lock after restart", lock, 1);

        // R6: rewrite same values, no relock
        write(1'b0, 1'b1, 6'd21);
        chk(lock == 1'b1, "R6 identical write", lock, 1);

        // R8: reset clears the sticky flag
        @(negedge vco_clk); rst_n = 1'b0;
        cyc(2);
        chk(over_limit == 1'b0, "R8 cleared by reset", over_limit, 0);
        rst_n = 1'b1;
        cyc(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule